// File: doc/BRIEF.md
# DES round subkey generator

This block turns a 64-bit DES key into the sixteen 48-bit round subkeys used by the cipher rounds. When the load strobe is high, the key is stripped of its eight parity bits and reordered into a 56-bit value. That value is stored as two 28-bit halves. For every round the halves are rotated left by the running total of the per-round shift amounts, rejoined and reduced to 48 bits. The result is the subkey for that round.

The round datapath drives a round index and an encrypt/decrypt select. One clock edge later, the block presents the matching subkey in a register together with a valid flag. In decrypt mode the subkeys come out in reverse order, so the round logic can count its index upward in both directions. The subkey is worked out from the stored halves and an absolute rotation offset. Any round can be asked for in any order, and nothing has to be rewound between blocks.

Top module: `des_key_schedule`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge clears `subkey_valid` to 0 and `subkey` to all zeros.
- R2: An edge with `load_key` high captures `key_in` and makes `subkey_valid` 0 after that edge. The first edge after it with `load_key` low sets `subkey_valid` to 1.
- R3: Key bits 8, 16, 24, 32, 40, 48, 56 and 64 have no effect on any subkey. Bit 1 is the most significant bit (`key_in[63]`), so these are `key_in[56]`, `key_in[48]` and so on down to `key_in[0]`.
- R4: With `decrypt` = 0 and `round_idx` = r (0 to 15), `subkey` is the standard DES subkey K(r+1). The halves are rotated left cumulatively by the per-round amounts 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1. Subkey bit 1 is `subkey[47]`. For the key 0x133457799BBCDFF1, K1 is 0x1B02EFFC7072 and K16 is 0xCB3D8B0E17F5.
- R5: With `decrypt` = 1 and `round_idx` = r, `subkey` is K(16-r), so index 0 yields K16 and index 15 yields K1.
- R6: K16 equals the 48-bit compression of the unrotated stored halves, because the sixteen shifts add up to a full 28-bit turn.
- R7: `subkey` reflects `round_idx` and `decrypt` as sampled at the previous clock edge. While both inputs stay the same and no key is loaded, `subkey` holds its value.
- R8: Changes on `key_in` while `load_key` is low have no effect on later subkeys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_key | input | 1 | Captures `key_in` on this edge |
| key_in | input | 64 | DES key, bit 1 = bit 63 |
| decrypt | input | 1 | 1 selects the reversed subkey order |
| round_idx | input | 4 | Round being requested, 0 to 15 |
| subkey | output | 48 | Registered round subkey |
| subkey_valid | output | 1 | Subkey is derived from a loaded key |

## Verification
The hardest case to reach from the ports is the wrap-around of the rotation offset. Round 16 must land back on the unrotated halves, and the decrypt order must map index 0 onto that same subkey. The stimulus reaches it by requesting index 15 in encrypt mode and index 0 in decrypt mode for several keys. Both results are compared with the compression of the plain parity-stripped key, and every round is also checked against a reference that rotates one step at a time. A separate pass flips only the parity bits, or only changes the key with the load strobe low, and then reads every round back.

// File: rtl/des_ks_pkg.sv
// Package: shared constants and selection tables for the DES key schedule.
// Assumes bit 1 of every vector is its most significant bit.
package des_ks_pkg;
    localparam int KEY_W    = 64;
    localparam int CD_W     = 56;
    localparam int HALF_W   = CD_W / 2;
    localparam int SUBKEY_W = 48;
    localparam int ROUNDS   = 16;
    localparam int RIDX_W   = $clog2(ROUNDS);
    localparam int ROT_W    = $clog2(HALF_W);

    // Source key bit (1-based) for each reduced-key position 1..56.
    localparam int unsigned PC1_SEL [CD_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };

    // Source position (1-based, in the rejoined halves) for subkey bits 1..48.
    localparam int unsigned PC2_SEL [SUBKEY_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    // Left shift applied in schedule step s (0-based).
    function automatic int unsigned step_shift(input int unsigned s);
        return (s == 0 || s == 1 || s == 8 || s == 15) ? 1 : 2;
    endfunction

    // Total left rotation of the halves for schedule step s, reduced modulo one turn.
    function automatic logic [ROT_W-1:0] cum_rotation(input logic [RIDX_W-1:0] s);
        int unsigned acc;
        acc = 0;
        for (int unsigned i = 0; i < ROUNDS; i++) begin
            if (i <= s) acc += step_shift(i);
        end
        return ROT_W'(acc % HALF_W);
    endfunction
endpackage

// File: rtl/des_ks_pc1.sv
// Module: parity-stripping key selection. Reorders 64 key bits into 56 and
// drops every eighth bit. Purely combinational.
module des_ks_pc1
    import des_ks_pkg::*;
(
    input  logic [KEY_W-1:0] key,
    output logic [CD_W-1:0]  cd
);
    // Route each reduced-key bit from its table-selected key bit.
    for (genvar i = 0; i < CD_W; i++) begin : g_sel
        assign cd[CD_W-1-i] = key[KEY_W - int'(PC1_SEL[i])];
    end

    // Parity positions are intentionally not routed anywhere.
    logic unused_parity;
    assign unused_parity = ^{key[56], key[48], key[40], key[32],
                             key[24], key[16], key[8],  key[0]};
endmodule

// File: rtl/des_ks_rotl.sv
// Module: variable left rotation of one key half. Assumes amt < W.
module des_ks_rotl #(
    parameter int W     = 28,
    parameter int AMT_W = 5
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     dout
);
    logic [2*W-1:0] doubled;

    // Shift a doubled copy so the upper half holds the rotated value.
    always_comb begin
        doubled = {din, din} << amt;
        dout    = doubled[2*W-1:W];
    end
endmodule

// File: rtl/des_ks_offset.sv
// Module: maps a requested round and direction to an absolute left rotation
// of the stored halves. Decrypt walks the schedule backwards.
module des_ks_offset
    import des_ks_pkg::*;
(
    input  logic              decrypt,
    input  logic [RIDX_W-1:0] round_idx,
    output logic [ROT_W-1:0]  rot_amt
);
    logic [RIDX_W-1:0] sched_step;

    // Pick the schedule step, then look up its accumulated rotation.
    always_comb begin
        sched_step = decrypt ? RIDX_W'(ROUNDS - 1) - round_idx : round_idx;
        rot_amt    = cum_rotation(sched_step);
    end
endmodule

// File: rtl/des_ks_pc2.sv
// Module: compression selection. Picks 48 of the 56 rejoined half bits.
// Purely combinational.
module des_ks_pc2
    import des_ks_pkg::*;
(
    input  logic [CD_W-1:0]     cd,
    output logic [SUBKEY_W-1:0] kout
);
    // Route each subkey bit from its table-selected position.
    for (genvar i = 0; i < SUBKEY_W; i++) begin : g_sel
        assign kout[SUBKEY_W-1-i] = cd[CD_W - int'(PC2_SEL[i])];
    end
endmodule

// File: rtl/des_key_schedule.sv
// Module: DES round subkey generator. Stores the parity-stripped key halves
// on load and registers the subkey for the requested round one edge later.
// Assumes round_idx stays within 0..15 and reset is synchronous, active low.
module des_key_schedule
    import des_ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_key,
    input  logic [63:0]       key_in,
    input  logic              decrypt,
    input  logic [3:0]        round_idx,
    output logic [47:0]       subkey,
    output logic              subkey_valid
);
    logic [CD_W-1:0]     cd_new;
    logic [HALF_W-1:0]   half_q [2];
    logic [HALF_W-1:0]   half_rot [2];
    logic [ROT_W-1:0]    rot_amt;
    logic [SUBKEY_W-1:0] subkey_d;
    logic [SUBKEY_W-1:0] subkey_q;
    logic                key_ok_q;
    logic                valid_q;

    des_ks_pc1 u_pc1 (
        .key (key_in),
        .cd  (cd_new)
    );

    des_ks_offset u_offset (
        .decrypt   (decrypt),
        .round_idx (round_idx),
        .rot_amt   (rot_amt)
    );

    // One rotator per half, both driven by the same offset.
    for (genvar h = 0; h < 2; h++) begin : g_half
        des_ks_rotl #(
            .W     (HALF_W),
            .AMT_W (ROT_W)
        ) u_rotl (
            .din  (half_q[h]),
            .amt  (rot_amt),
            .dout (half_rot[h])
        );
    end

    des_ks_pc2 u_pc2 (
        .cd   ({half_rot[0], half_rot[1]}),
        .kout (subkey_d)
    );

    // Key storage: capture the halves only when the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q[0] <= '0;
            half_q[1] <= '0;
            key_ok_q  <= 1'b0;
        end else if (load_key) begin
            half_q[0] <= cd_new[CD_W-1:HALF_W];
            half_q[1] <= cd_new[HALF_W-1:0];
            key_ok_q  <= 1'b1;
        end
    end

    // Output register: the subkey for the sampled round, flagged once a key is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            subkey_q <= '0;
            valid_q  <= 1'b0;
        end else if (load_key) begin
            valid_q  <= 1'b0;
        end else begin
            subkey_q <= subkey_d;
            valid_q  <= key_ok_q;
        end
    end

    assign subkey       = subkey_q;
    assign subkey_valid = valid_q;
endmodule

// File: rtl/des_key_schedule_chk.sv
// Checker: temporal properties of the subkey generator ports, bound to the top.
module des_key_schedule_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load_key,
    input logic        decrypt,
    input logic [3:0]  round_idx,
    input logic [47:0] subkey,
    input logic        subkey_valid
);
    // Reset edge leaves output cleared.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!subkey_valid && subkey == '0));

    // A load edge drops the valid flag.
    assert_load_drops_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_key |=> !subkey_valid);

    // The first non-load edge after a load raises the valid flag.
    assert_valid_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_key && $past(load_key)) |=> subkey_valid);

    // Unchanged request and no load keep the subkey steady.
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (subkey_valid && !load_key && $stable(round_idx) && $stable(decrypt))
        |=> $stable(subkey));
endmodule

bind des_key_schedule des_key_schedule_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_key     (load_key),
    .decrypt      (decrypt),
    .round_idx    (round_idx),
    .subkey       (subkey),
    .subkey_valid (subkey_valid)
);

// File: tb/des_key_schedule_tb_top.sv
// Bench: directed scenarios for the DES subkey generator, with a stepwise reference model.
module des_key_schedule_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_key = 1'b0;
    logic [63:0] key_in = '0;
    logic        decrypt = 1'b0;
    logic [3:0]  round_idx = '0;
    logic [47:0] subkey;
    logic        subkey_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    des_key_schedule dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_key     (load_key),
        .key_in       (key_in),
        .decrypt      (decrypt),
        .round_idx    (round_idx),
        .subkey       (subkey),
        .subkey_valid (subkey_valid)
    );

    always #5 clk = ~clk;

    localparam int REF_PC1 [56] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};
    localparam int REF_PC2 [48] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};
    localparam int REF_SHIFT [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

    function automatic logic [55:0] ref_pc1(input logic [63:0] k);
        logic [55:0] r;
        for (int i = 0; i < 56; i++) r[55-i] = k[64-REF_PC1[i]];
        return r;
    endfunction

    function automatic logic [47:0] ref_pc2(input logic [55:0] cd);
        logic [47:0] r;
        for (int i = 0; i < 48; i++) r[47-i] = cd[56-REF_PC2[i]];
        return r;
    endfunction

    // Subkey Kn (n = 1..16), rotating one step at a time.
    function automatic logic [47:0] ref_subkey(input logic [63:0] k, input int n);
        logic [55:0] cd;
        logic [27:0] c, d;
        cd = ref_pc1(k);
        c = cd[55:28];
        d = cd[27:0];
        for (int r = 0; r < n; r++) begin
            for (int s = 0; s < REF_SHIFT[r]; s++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
        end
        return ref_pc2({c, d});
    endfunction

    task automatic check48(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [63:0] k);
        @(negedge clk);
        key_in = k;
        load_key = 1'b1;
        @(negedge clk);
        load_key = 1'b0;
    endtask

    task automatic request(input logic dec, input int idx);
        @(negedge clk);
        decrypt = dec;
        round_idx = 4'(idx);
        @(negedge clk);
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check1("R1 valid", subkey_valid, 1'b0);
        check48("R1 subkey", subkey, 48'h0);
        rst_n = 1'b1;
    endtask

    // R2: valid timing around a load.
    task automatic t_load_timing();
        @(negedge clk);
        key_in = 64'h0123456789ABCDEF;
        load_key = 1'b1;
        @(negedge clk);
        load_key = 1'b0;
        check1("R2 valid low after load", subkey_valid, 1'b0);
        @(negedge clk);
        check1("R2 valid high next", subkey_valid, 1'b1);
    endtask

    // R4/R5: published vector endpoints.
    task automatic t_known_vector();
        do_load(64'h133457799BBCDFF1);
        request(1'b0, 0);
        check48("R4 K1 vector", subkey, 48'h1B02EFFC7072);
        request(1'b0, 15);
        check48("R4 K16 vector", subkey, 48'hCB3D8B0E17F5);
        request(1'b1, 0);
        check48("R5 decrypt first is K16", subkey, 48'hCB3D8B0E17F5);
        request(1'b1, 15);
        check48("R5 decrypt last is K1", subkey, 48'h1B02EFFC7072);
    endtask

    // R4/R5: every round in both directions against the stepwise model.
    task automatic t_all_rounds(input logic [63:0] k);
        do_load(k);
        for (int r = 0; r < 16; r++) begin
            request(1'b0, r);
            check48("R4 encrypt round", subkey, ref_subkey(k, r + 1));
        end
        for (int r = 0; r < 16; r++) begin
            request(1'b1, r);
            check48("R5 decrypt round", subkey, ref_subkey(k, 16 - r));
        end
    endtask

    // R6: last round lands on the unrotated halves.
    task automatic t_wrap(input logic [63:0] k);
        do_load(k);
        request(1'b0, 15);
        check48("R6 K16 unrotated", subkey, ref_pc2(ref_pc1(k)));
        request(1'b1, 0);
        check48("R6 decrypt idx0 unrotated", subkey, ref_pc2(ref_pc1(k)));
    endtask

    // R3: parity bits flipped give identical subkeys.
    task automatic t_parity();
        logic [63:0] k = 64'h8F3C_5A96_2B71_E4D0;
        logic [47:0] base [16];
        do_load(k);
        for (int r = 0; r < 16; r++) begin
            request(1'b0, r);
            base[r] = subkey;
        end
        do_load(k ^ 64'h0101_0101_0101_0101);
        for (int r = 0; r < 16; r++) begin
            request(1'b0, r);
            check48("R3 parity ignored", subkey, base[r]);
        end
    endtask

    // R8: key changes without the strobe are not captured.
    task automatic t_no_load();
        logic [63:0] k = 64'hFEDC_BA98_7654_3210;
        do_load(k);
        @(negedge clk);
        key_in = ~k;
        for (int r = 0; r < 16; r += 5) begin
            request(1'b0, r);
            check48("R8 no capture without load", subkey, ref_subkey(k, r + 1));
        end
        key_in = 64'h0;
        request(1'b1, 3);
        check48("R8 no capture decrypt", subkey, ref_subkey(k, 13));
    endtask

    // R7: output lags the request by one edge and then holds.
    task automatic t_hold();
        logic [63:0] k = 64'h0F1E_2D3C_4B5A_6978;
        do_load(k);
        request(1'b0, 4);
        @(negedge clk);
        round_idx = 4'd9;
        check48("R7 old value before edge", subkey, ref_subkey(k, 5));
        @(negedge clk);
        check48("R7 new value after edge", subkey, ref_subkey(k, 10));
        repeat (3) @(negedge clk);
        check48("R7 held", subkey, ref_subkey(k, 10));
    endtask

    // Extreme keys: all zeros and all ones map to constant subkeys.
    task automatic t_extremes();
        do_load(64'h0);
        request(1'b0, 7);
        check48("R4 zero key", subkey, 48'h0);
        do_load(64'hFFFF_FFFF_FFFF_FFFF);
        request(1'b1, 11);
        check48("R5 ones key", subkey, 48'hFFFF_FFFF_FFFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load_timing();
        t_known_vector();
        t_all_rounds(64'h133457799BBCDFF1);
        t_all_rounds(64'hA5C3_19E7_6B2D_F048);
        t_wrap(64'h3B7A_C1D9_5E20_84F6);
        t_wrap(64'h133457799BBCDFF1);
        t_parity();
        t_no_load();
        t_hold();
        t_extremes();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule